// File: doc/BRIEF.md
# Dual-Clock FIFO with Re-timed Ready Flags

This block is a 64-entry, 36-bit first-in first-out queue whose writer and reader run on unrelated clocks. The writer presents a word and a write strobe, and sees two active-low style "room" indications on its own clock: a full indication and an almost-full indication. The reader raises a fetch strobe to move the oldest word into a registered output stage. On its own clock it sees a "word available" indication and an almost-empty indication.

Each side keeps a binary pointer and publishes a Gray-coded copy. The copy crosses into the other clock domain through two flip-flop stages and is converted back to binary there. Each side's flags come from comparing its own pointer with the synchronized remote pointer. A word written into an empty queue can therefore be fetched on the third read-clock edge. The almost-flag offset X is captured during reset from a two-bit code and is held until the next reset.

A single asynchronous active-low reset clears both sides. Each clock domain releases the reset through its own two-stage synchronizer.

Top module: `xfifo_dual_clk`

## Requirements
- R1: While reset is applied and right after it is released, `avail_n` and `near_empty_n` are LOW, `room_n` and `near_full_n` are HIGH, and `rd_data` is all zeros.
- R2: Words come out in the order they were written, with all 36 bits intact. A fetch accepted on a read-clock edge places the oldest word on `rd_data` after that edge, and `rd_data` keeps that value until the next accepted fetch.
- R3: After a word is written into an empty queue, `avail_n` is still LOW after the first read-clock rising edge that follows the write and is HIGH after the second. A fetch on the next edge (the third) delivers the word.
- R4: `room_n` is LOW exactly when 64 words are held. A write strobe while `room_n` is LOW stores nothing: the words read out afterwards are the earlier 64 only.
- R5: A fetch strobe while `avail_n` is LOW has no effect: `rd_data` does not change and no word is consumed.
- R6: After a fetch from a full queue, `room_n` is still LOW after the first write-clock rising edge that follows the fetch and is HIGH after the second.
- R7: Once settled, `near_empty_n` is LOW when the queue holds X words or fewer and HIGH when it holds X+1 or more.
- R8: Once settled, `near_full_n` is LOW when the queue holds 64−X words or more and HIGH when it holds 63−X or fewer.
- R9: X is taken from `thr_code` while reset is applied. Codes 00, 01, 10 and 11 select 16, 12, 8 and 4. Changing `thr_code` after reset release does not change X.
- R10: Ordering and flags stay correct when both pointers wrap several times while writes and fetches run concurrently on both clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| thr_code | input | 2 | Almost-flag offset select, captured during reset |
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 36 | Word to store |
| room_n | output | 1 | HIGH while at least one entry is free |
| near_full_n | output | 1 | LOW when 64−X or more words are held |
| rd_clk | input | 1 | Read-side clock |
| rd_en | input | 1 | Fetch strobe |
| rd_data | output | 36 | Registered output word |
| avail_n | output | 1 | HIGH while a word can be fetched |
| near_empty_n | output | 1 | LOW when X or fewer words are held |

## Verification
A single word into an empty queue separates a correct two-edge flag delay and three-edge fetch latency from designs that are one stage short or one stage long. Filling to capacity and then issuing an extra write tells a dropped write from an overwrite. A single fetch then measures the two-edge recovery of the room flag. For every offset code, fill levels placed one word on each side of X and of 64−X catch off-by-one threshold errors and an offset that follows `thr_code` after reset. A 300-word concurrent stream, with the writer faster than the reader, wraps both pointers more than twice. It exposes Gray conversion and wrap errors that a single pass would miss.

// File: rtl/xfifo_pkg.sv
`timescale 1ns/1ps
package xfifo_pkg;

  // Offset select codes captured during reset
  typedef enum logic [1:0] {
    TH_WIDE   = 2'b00,
    TH_MID    = 2'b01,
    TH_NARROW = 2'b10,
    TH_TIGHT  = 2'b11
  } thr_code_e;

  function automatic int unsigned thr_words(input logic [1:0] code);
    int unsigned w;
    case (thr_code_e'(code))
      TH_WIDE:   w = 16;
      TH_MID:    w = 12;
      TH_NARROW: w = 8;
      default:   w = 4;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/xfifo_rst_sync.sv
`timescale 1ns/1ps
module xfifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      srst_n  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      srst_n  <= stage_q;
    end
  end

endmodule

// File: rtl/xfifo_ptr_sync.sv
`timescale 1ns/1ps
module xfifo_ptr_sync #(
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);

  logic [PW-1:0] meta_q;
  logic [PW-1:0] sync_q;
  logic [PW-1:0] bin_c;
  logic          acc;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  // Gray to binary: each bit is the XOR of all Gray bits at or above it
  always_comb begin
    acc   = 1'b0;
    bin_c = '0;
    for (int i = PW - 1; i >= 0; i--) begin
      acc      = acc ^ sync_q[i];
      bin_c[i] = acc;
    end
  end

  assign bin_out = bin_c;

endmodule

// File: rtl/xfifo_store.sv
`timescale 1ns/1ps
module xfifo_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 36,
  parameter int AW    = 6
) (
  input  logic             wclk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/xfifo_wr_ctl.sv
`timescale 1ns/1ps
module xfifo_wr_ctl
  import xfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int PW    = 7
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic [1:0]    thr_code,
  input  logic          wr_en,
  input  logic [PW-1:0] rd_bin_sync,
  output logic          wr_fire,
  output logic [AW-1:0] wr_addr,
  output logic [PW-1:0] wr_gray,
  output logic          room_n,
  output logic          near_full_n
);

  logic [PW-1:0] wbin_q, wbin_d, wgray_d;
  logic [PW-1:0] x_q, x_d;
  logic          x_load;
  logic [PW-1:0] fill;
  logic [PW-1:0] af_limit;

  // Next-state
  always_comb begin
    wbin_d = wbin_q;
    if (wr_fire) begin
      wbin_d = wbin_q + PW'(1);
    end
    wgray_d = wbin_d ^ (wbin_d >> 1);
    x_load  = ~srst_n;
    x_d     = PW'(thr_words(thr_code));
  end

  // Pointer registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      wbin_q  <= '0;
      wr_gray <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wr_gray <= wgray_d;
    end
  end

  // Offset register, loaded while the domain is held in reset
  always_ff @(posedge clk) begin
    if (x_load) begin
      x_q <= x_d;
    end
  end

  // Flags
  assign fill        = wbin_q - rd_bin_sync;
  assign af_limit    = PW'(DEPTH) - x_q;
  assign room_n      = (fill != PW'(DEPTH));
  assign near_full_n = (fill < af_limit);
  assign wr_fire     = wr_en & room_n;
  assign wr_addr     = wbin_q[AW-1:0];

  AST_FULL_BLOCKS_WR: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && !room_n) |=> $stable(wbin_q));                               // R4
  AST_WR_STEP: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && room_n) |=> (wbin_q == $past(wbin_q) + PW'(1)));             // R2
  AST_FILL_CAP_WR: assert property (@(posedge clk) disable iff (!srst_n)
    fill <= PW'(DEPTH));                                                   // R4
  AST_NEAR_FULL_WHEN_FULL: assert property (@(posedge clk) disable iff (!srst_n)
    !room_n |-> !near_full_n);                                             // R8
  AST_WR_GRAY_STEP: assert property (@(posedge clk) disable iff (!srst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);                            // R10
  AST_X_HELD_WR: assert property (@(posedge clk) disable iff (!srst_n)
    $stable(x_q));                                                         // R9

endmodule

// File: rtl/xfifo_rd_ctl.sv
`timescale 1ns/1ps
module xfifo_rd_ctl
  import xfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 36,
  parameter int AW    = 6,
  parameter int PW    = 7
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic [1:0]       thr_code,
  input  logic             rd_en,
  input  logic [PW-1:0]    wr_bin_sync,
  input  logic [WIDTH-1:0] mem_rdata,
  output logic [AW-1:0]    rd_addr,
  output logic [PW-1:0]    rd_gray,
  output logic [WIDTH-1:0] rd_data,
  output logic             avail_n,
  output logic             near_empty_n
);

  logic [PW-1:0]    rbin_q, rbin_d, rgray_d;
  logic [WIDTH-1:0] data_d;
  logic             rd_fire;
  logic [PW-1:0]    x_q, x_d;
  logic             x_load;
  logic [PW-1:0]    fill;

  // Next-state
  always_comb begin
    rbin_d = rbin_q;
    data_d = rd_data;
    if (rd_fire) begin
      rbin_d = rbin_q + PW'(1);
      data_d = mem_rdata;
    end
    rgray_d = rbin_d ^ (rbin_d >> 1);
    x_load  = ~srst_n;
    x_d     = PW'(thr_words(thr_code));
  end

  // Pointer and output registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rbin_q  <= '0;
      rd_gray <= '0;
      rd_data <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rd_gray <= rgray_d;
      rd_data <= data_d;
    end
  end

  // Offset register, loaded while the domain is held in reset
  always_ff @(posedge clk) begin
    if (x_load) begin
      x_q <= x_d;
    end
  end

  // Flags
  assign fill         = wr_bin_sync - rbin_q;
  assign avail_n      = (fill != '0);
  assign near_empty_n = (fill > x_q);
  assign rd_fire      = rd_en & avail_n;
  assign rd_addr      = rbin_q[AW-1:0];

  AST_EMPTY_BLOCKS_RD: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_en && !avail_n) |=> ($stable(rbin_q) && $stable(rd_data)));        // R5
  AST_RD_STEP: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_en && avail_n) |=> (rbin_q == $past(rbin_q) + PW'(1)));            // R2
  AST_FILL_CAP_RD: assert property (@(posedge clk) disable iff (!srst_n)
    fill <= PW'(DEPTH));                                                   // R10
  AST_NEAR_EMPTY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!srst_n)
    !avail_n |-> !near_empty_n);                                           // R7
  AST_RD_GRAY_STEP: assert property (@(posedge clk) disable iff (!srst_n)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);                            // R10
  AST_X_HELD_RD: assert property (@(posedge clk) disable iff (!srst_n)
    $stable(x_q));                                                         // R9

endmodule

// File: rtl/xfifo_dual_clk.sv
`timescale 1ns/1ps
module xfifo_dual_clk #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 36
) (
  input  logic             rst_n,
  input  logic [1:0]       thr_code,
  input  logic             wr_clk,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             room_n,
  output logic             near_full_n,
  input  logic             rd_clk,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             avail_n,
  output logic             near_empty_n
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic             wr_srst_n, rd_srst_n;
  logic [PW-1:0]    wr_gray, rd_gray;
  logic [PW-1:0]    wr_bin_at_rd, rd_bin_at_wr;
  logic             wr_fire;
  logic [AW-1:0]    wr_addr, rd_addr;
  logic [WIDTH-1:0] mem_rdata;

  xfifo_rst_sync u_wr_rst (.clk(wr_clk), .arst_n(rst_n), .srst_n(wr_srst_n));
  xfifo_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(rst_n), .srst_n(rd_srst_n));

  xfifo_ptr_sync #(.PW(PW)) u_rd2wr (
    .clk(wr_clk), .srst_n(wr_srst_n), .gray_in(rd_gray), .bin_out(rd_bin_at_wr)
  );
  xfifo_ptr_sync #(.PW(PW)) u_wr2rd (
    .clk(rd_clk), .srst_n(rd_srst_n), .gray_in(wr_gray), .bin_out(wr_bin_at_rd)
  );

  xfifo_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .clk(wr_clk), .srst_n(wr_srst_n), .thr_code(thr_code), .wr_en(wr_en),
    .rd_bin_sync(rd_bin_at_wr), .wr_fire(wr_fire), .wr_addr(wr_addr),
    .wr_gray(wr_gray), .room_n(room_n), .near_full_n(near_full_n)
  );

  xfifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_store (
    .wclk(wr_clk), .we(wr_fire), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(mem_rdata)
  );

  xfifo_rd_ctl #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW), .PW(PW)) u_rd (
    .clk(rd_clk), .srst_n(rd_srst_n), .thr_code(thr_code), .rd_en(rd_en),
    .wr_bin_sync(wr_bin_at_rd), .mem_rdata(mem_rdata), .rd_addr(rd_addr),
    .rd_gray(rd_gray), .rd_data(rd_data), .avail_n(avail_n),
    .near_empty_n(near_empty_n)
  );

endmodule

// File: tb/tb_xfifo_dual_clk.sv
`timescale 1ns/1ps
module tb_xfifo_dual_clk;

  localparam int DEPTH = 64;
  localparam int WIDTH = 36;

  logic             rst_n;
  logic [1:0]       thr_code;
  logic             wr_clk, rd_clk;
  logic             wr_en, rd_en;
  logic [WIDTH-1:0] wr_data;
  logic [WIDTH-1:0] rd_data;
  logic             room_n, near_full_n, avail_n, near_empty_n;

  int checks = 0;
  int errors = 0;
  int head = 0;
  int tail = 0;
  logic [WIDTH-1:0] mdl [0:4095];

  xfifo_dual_clk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .rst_n(rst_n), .thr_code(thr_code),
    .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
    .room_n(room_n), .near_full_n(near_full_n),
    .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(rd_data),
    .avail_n(avail_n), .near_empty_n(near_empty_n)
  );

  // 100 MHz write clock, rising edges at odd multiples of 5 ns
  initial begin
    wr_clk = 1'b0;
    forever #5 wr_clk = ~wr_clk;
  end
  // 62.5 MHz read clock, rising edges at 8 + 16k ns (never aligned with write edges)
  initial begin
    rd_clk = 1'b0;
    forever #8 rd_clk = ~rd_clk;
  end

  function automatic logic [WIDTH-1:0] pat(input int n);
    logic [31:0] v;
    v = 32'(n) * 32'h9E37_79B1 + 32'h0001_3579;
    return {4'(n) ^ 4'h5, v};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] code);
    rst_n    = 1'b0;
    wr_en    = 1'b0;
    rd_en    = 1'b0;
    wr_data  = '0;
    thr_code = code;
    repeat (4) @(negedge rd_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge rd_clk);
    head = 0;
    tail = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge rd_clk);
  endtask

  task automatic push(input logic [WIDTH-1:0] d, output bit ok);
    @(negedge wr_clk);
    ok      = room_n;
    wr_en   = 1'b1;
    wr_data = d;
    @(posedge wr_clk);
    wr_en <= 1'b0;
    if (ok) begin
      mdl[tail] = d;
      tail++;
    end
  endtask

  task automatic pop(output logic [WIDTH-1:0] d, output bit ok);
    @(negedge rd_clk);
    ok    = avail_n;
    rd_en = 1'b1;
    @(posedge rd_clk);
    rd_en <= 1'b0;
    @(negedge rd_clk);
    d = rd_data;
  endtask

  task automatic fill_to(input int level, input int base);
    bit ok;
    while ((tail - head) < level) push(pat(base + tail), ok);
  endtask

  task automatic drain(input string req);
    logic [WIDTH-1:0] d;
    bit ok;
    while (head != tail) begin
      pop(d, ok);
      if (ok) begin
        check(req, 64'(d), 64'(mdl[head]));
        head++;
      end
    end
  endtask

  // R1
  task automatic t_reset();
    do_reset(2'b10);
    check("R1 avail_n", 64'(avail_n), 64'd0);
    check("R1 near_empty_n", 64'(near_empty_n), 64'd0);
    check("R1 room_n", 64'(room_n), 64'd1);
    check("R1 near_full_n", 64'(near_full_n), 64'd1);
    check("R1 rd_data", 64'(rd_data), 64'd0);
  endtask

  // R3, R2, R5
  task automatic t_first_word();
    logic [WIDTH-1:0] d;
    logic [WIDTH-1:0] a;
    bit ok;
    do_reset(2'b10);
    a = 36'hA_5A5A_0F0F;
    @(negedge wr_clk);
    wr_en   = 1'b1;
    wr_data = a;
    @(posedge wr_clk);
    wr_en <= 1'b0;
    @(posedge rd_clk);
    @(negedge rd_clk);
    check("R3 flag after first edge", 64'(avail_n), 64'd0);
    @(posedge rd_clk);
    @(negedge rd_clk);
    check("R3 flag after second edge", 64'(avail_n), 64'd1);
    rd_en = 1'b1;
    @(posedge rd_clk);
    rd_en <= 1'b0;
    @(negedge rd_clk);
    check("R3 word on third edge", 64'(rd_data), 64'(a));
    check("R5 empty after fetch", 64'(avail_n), 64'd0);
    for (int i = 0; i < 3; i++) begin
      pop(d, ok);
      check("R5 fetch ignored when empty", 64'(ok), 64'd0);
      check("R5 rd_data held", 64'(d), 64'(a));
    end
    push(36'h3_1234_5678, ok);
    settle();
    pop(d, ok);
    check("R5 no word consumed", 64'(d), 64'h3_1234_5678);
    check("R2 hold without fetch", 64'(rd_data), 64'h3_1234_5678);
  endtask

  // R4, R6, R8
  task automatic t_full();
    logic [WIDTH-1:0] d;
    bit ok;
    do_reset(2'b10);
    fill_to(DEPTH, 100);
    settle();
    check("R4 room_n at 64", 64'(room_n), 64'd0);
    check("R8 near_full_n at 64", 64'(near_full_n), 64'd0);
    push(36'hF_DEAD_BEEF, ok);
    check("R4 write refused when full", 64'(ok), 64'd0);
    @(negedge rd_clk);
    rd_en = 1'b1;
    @(posedge rd_clk);
    rd_en <= 1'b0;
    @(posedge wr_clk);
    @(negedge wr_clk);
    check("R6 room after first edge", 64'(room_n), 64'd0);
    @(posedge wr_clk);
    @(negedge wr_clk);
    check("R6 room after second edge", 64'(room_n), 64'd1);
    check("R2 first word out", 64'(rd_data), 64'(mdl[head]));
    head++;
    drain("R4 order after refused write");
    settle();
    check("R4 empty after 64 words", 64'(avail_n), 64'd0);
  endtask

  // R7, R8, R9
  task automatic t_thresh(input logic [1:0] code, input int x);
    logic [WIDTH-1:0] d;
    bit ok;
    do_reset(code);
    thr_code = ~code;
    fill_to(x, 500);
    settle();
    check("R7 near_empty_n at X", 64'(near_empty_n), 64'd0);
    check("R7 avail_n at X", 64'(avail_n), 64'd1);
    fill_to(x + 1, 500);
    settle();
    check("R7 R9 near_empty_n at X+1", 64'(near_empty_n), 64'd1);
    fill_to(DEPTH - x - 1, 500);
    settle();
    check("R8 near_full_n at 63-X", 64'(near_full_n), 64'd1);
    fill_to(DEPTH - x, 500);
    settle();
    check("R8 R9 near_full_n at 64-X", 64'(near_full_n), 64'd0);
    pop(d, ok);
    check("R2 fetch data", 64'(d), 64'(mdl[head]));
    head++;
    settle();
    check("R8 near_full_n back at 63-X", 64'(near_full_n), 64'd1);
    drain("R2 drain order");
    settle();
    check("R7 near_empty_n when empty", 64'(near_empty_n), 64'd0);
  endtask

  // R10
  task automatic t_stream();
    do_reset(2'b11);
    fork
      begin
        int n = 0;
        bit ok;
        while (n < 300) begin
          push(pat(2000 + n), ok);
          if (ok) n++;
        end
      end
      begin
        int m = 0;
        bit ok;
        logic [WIDTH-1:0] d;
        while (m < 300) begin
          pop(d, ok);
          if (ok) begin
            check("R10 stream word", 64'(d), 64'(mdl[head]));
            head++;
            m++;
          end
        end
      end
    join
    settle();
    check("R10 empty at end", 64'(avail_n), 64'd0);
    check("R10 room at end", 64'(room_n), 64'd1);
  endtask

  initial begin
    rst_n    = 1'b0;
    wr_en    = 1'b0;
    rd_en    = 1'b0;
    wr_data  = '0;
    thr_code = 2'b10;
    t_reset();
    t_first_word();
    t_full();
    t_thresh(2'b00, 16);
    t_thresh(2'b01, 12);
    t_thresh(2'b10, 8);
    t_thresh(2'b11, 4);
    t_stream();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule